// File: doc/BRIEF.md
# Prefetch-Address Branch Target Predictor

This block is a small, fully associative table that sits beside the instruction prefetch unit. Each cycle the prefetcher presents the address it is about to fetch from. If that address belongs to a branch whose most recent execution was taken, the block raises a hit flag in the same cycle. It also supplies the remembered destination as the next fetch address, so the fetcher can move to the new instruction stream before the branch is decoded. On a miss, or when the branch last fell through, the next fetch address is the sequential one. Because the prediction comes from the fetch address, store access time after a taken branch can be overlapped with the work of earlier pipeline stages.

The table is trained by a resolved-branch port driven from the control point. That port gives the branch address, whether the branch was taken, its destination, and whether the destination was encoded as a literal operand. Only literal-destination branches can claim an entry, and only on a taken execution. A branch already in the table keeps its entry. Each execution rewrites its single history bit, and a taken execution also rewrites its destination. When the table is full, a round-robin pointer selects the entry to replace.

Top module: `jump_trace_predictor`

## Requirements
- R1: While reset is asserted and after it is released, every entry is empty, so `pred_hit` is 0 and `pred_next` equals `fetch_addr + 1` (modulo 2^ADDR_W) for every address until an entry is allocated.
- R2: When no valid entry holds `fetch_addr` with its history bit set, `pred_hit` is 0 and `pred_next` is `fetch_addr + 1` (modulo 2^ADDR_W).
- R3: A taken update with `upd_literal` = 0 for an address not in the table creates no entry. Later lookups of that address miss.
- R4: A not-taken update for an address not in the table creates no entry, whatever the value of `upd_literal`.
- R5: A taken update with `upd_literal` = 1 for an address not in the table creates an entry with its history bit set. From the next cycle, a lookup of that address gives `pred_hit` = 1 and `pred_next` = the update's target.
- R6: A not-taken update for an address already in the table clears that entry's history bit without removing the entry, so lookups of it then miss.
- R7: A taken update for an address already in the table sets its history bit and replaces its target, whatever the value of `upd_literal`, and uses no new entry.
- R8: An allocation uses the lowest-numbered empty entry if there is one. Otherwise it overwrites the entry under the round-robin pointer, which starts at entry 0 after reset and advances by one, wrapping from ENTRIES-1 to 0, after each such overwrite. An address is never held by more than one entry.
- R9: Lookup is combinational. An update in the same cycle as a lookup of the same address does not change that cycle's outputs and takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_addr | input | ADDR_W | Address being prefetched this cycle |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_addr | input | ADDR_W | Address of the resolved branch |
| upd_taken | input | 1 | 1 when the resolved branch was taken |
| upd_target | input | ADDR_W | Destination of the resolved branch |
| upd_literal | input | 1 | 1 when the destination came from a literal operand |
| pred_hit | output | 1 | Fetch address is predicted to branch |
| pred_next | output | ADDR_W | Predicted next fetch address |

## Verification
A corrupted tag, target or history bit shows at the ports as soon as that address is fetched. The symptom is a wrong hit flag, or a hit that steers fetch to the wrong destination, with no delay beyond the combinational lookup. A wrong replacement pointer, a wrong empty-slot choice or a spurious allocation does not show at once. It appears one or more allocations later, when an address that should have been kept misses or an evicted one still hits. For this reason the bench sweeps every address in a small window after each update and compares against an arithmetic model of the table. This covers the eviction order across several wraps of the pointer.

// File: rtl/jtp_pkg.sv
package jtp_pkg;

  typedef enum logic [1:0] {
    UPD_IDLE    = 2'd0,
    UPD_REFRESH = 2'd1,
    UPD_DEMOTE  = 2'd2,
    UPD_CLAIM   = 2'd3
  } upd_kind_e;

  function automatic upd_kind_e classify_update(
    input logic valid,
    input logic taken,
    input logic literal,
    input logic present
  );
    upd_kind_e kind;
    kind = UPD_IDLE;
    if (valid) begin
      if (present) kind = taken ? UPD_REFRESH : UPD_DEMOTE;
      else if (taken && literal) kind = UPD_CLAIM;
    end
    return kind;
  endfunction

endpackage

// File: rtl/jtp_entry.sv
module jtp_entry #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              claim_en,
  input  logic              set_en,
  input  logic              clr_en,
  input  logic [ADDR_W-1:0] new_target,
  output logic              valid_o,
  output logic              lk_match_o,
  output logic              up_match_o,
  output logic              taken_o,
  output logic [ADDR_W-1:0] target_o
);

  logic              valid_q, valid_d;
  logic              taken_q, taken_d;
  logic [ADDR_W-1:0] tag_q, tag_d;
  logic [ADDR_W-1:0] target_q, target_d;
  logic              load_en;

  assign load_en = claim_en | set_en | clr_en;

  always_comb begin
    valid_d  = valid_q;
    taken_d  = taken_q;
    tag_d    = tag_q;
    target_d = target_q;
    if (claim_en) begin
      valid_d  = 1'b1;
      taken_d  = 1'b1;
      tag_d    = up_addr;
      target_d = new_target;
    end else if (set_en) begin
      taken_d  = 1'b1;
      target_d = new_target;
    end else if (clr_en) begin
      taken_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      taken_q  <= 1'b0;
      tag_q    <= '0;
      target_q <= '0;
    end else if (load_en) begin
      valid_q  <= valid_d;
      taken_q  <= taken_d;
      tag_q    <= tag_d;
      target_q <= target_d;
    end
  end

  assign valid_o    = valid_q;
  assign lk_match_o = valid_q && (tag_q == lk_addr);
  assign up_match_o = valid_q && (tag_q == up_addr);
  assign taken_o    = taken_q;
  assign target_o   = target_q;

endmodule

// File: rtl/jtp_victim.sv
module jtp_victim #(
  parameter int ENTRIES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic               claim_req,
  output logic [ENTRIES-1:0] claim_vec
);

  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [PTR_W-1:0] free_idx;
  logic [PTR_W-1:0] victim_idx;
  logic             any_free;
  logic             ptr_en;

  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!valid_vec[i]) begin
        any_free = 1'b1;
        free_idx = PTR_W'(i);
      end
    end
  end

  assign victim_idx = any_free ? free_idx : ptr_q;
  assign ptr_en     = claim_req && !any_free;

  always_comb begin
    claim_vec = '0;
    if (claim_req) claim_vec[victim_idx] = 1'b1;
  end

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_en) ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

endmodule

// File: rtl/jtp_select.sv
module jtp_select #(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 16
) (
  input  logic [ENTRIES-1:0]        lk_match_vec,
  input  logic [ENTRIES-1:0]        taken_vec,
  input  logic [ENTRIES*ADDR_W-1:0] target_bus,
  input  logic [ADDR_W-1:0]         seq_addr,
  output logic                      hit,
  output logic [ADDR_W-1:0]         next_addr
);

  logic [ENTRIES-1:0] sel_vec;
  logic [ADDR_W-1:0]  sel_target;

  assign sel_vec = lk_match_vec & taken_vec;
  assign hit     = |sel_vec;

  always_comb begin
    sel_target = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (sel_vec[i]) sel_target = sel_target | target_bus[i*ADDR_W +: ADDR_W];
    end
  end

  assign next_addr = hit ? sel_target : seq_addr;

endmodule

// File: rtl/jump_trace_predictor.sv
module jump_trace_predictor #(
  parameter int ADDR_W  = 16,
  parameter int ENTRIES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_addr,
  input  logic              upd_taken,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic              upd_literal,
  output logic              pred_hit,
  output logic [ADDR_W-1:0] pred_next
);

  import jtp_pkg::*;

  logic [ENTRIES-1:0]        valid_vec;
  logic [ENTRIES-1:0]        lk_hit_vec;
  logic [ENTRIES-1:0]        up_hit_vec;
  logic [ENTRIES-1:0]        taken_vec;
  logic [ENTRIES-1:0]        claim_vec;
  logic [ENTRIES-1:0]        set_vec;
  logic [ENTRIES-1:0]        clr_vec;
  logic [ENTRIES*ADDR_W-1:0] target_bus;
  logic [ADDR_W-1:0]         seq_addr;
  logic                      up_present;
  upd_kind_e                 upd_kind;

  assign up_present = |up_hit_vec;
  assign upd_kind   = classify_update(upd_valid, upd_taken, upd_literal, up_present);
  assign set_vec    = (upd_kind == UPD_REFRESH) ? up_hit_vec : '0;
  assign clr_vec    = (upd_kind == UPD_DEMOTE)  ? up_hit_vec : '0;
  assign seq_addr   = fetch_addr + ADDR_W'(1);

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    jtp_entry #(.ADDR_W(ADDR_W)) u_entry (
      .clk        (clk),
      .rst_n      (rst_n),
      .lk_addr    (fetch_addr),
      .up_addr    (upd_addr),
      .claim_en   (claim_vec[g]),
      .set_en     (set_vec[g]),
      .clr_en     (clr_vec[g]),
      .new_target (upd_target),
      .valid_o    (valid_vec[g]),
      .lk_match_o (lk_hit_vec[g]),
      .up_match_o (up_hit_vec[g]),
      .taken_o    (taken_vec[g]),
      .target_o   (target_bus[g*ADDR_W +: ADDR_W])
    );
  end

  jtp_victim #(.ENTRIES(ENTRIES)) u_victim (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid_vec (valid_vec),
    .claim_req (upd_kind == UPD_CLAIM),
    .claim_vec (claim_vec)
  );

  jtp_select #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_select (
    .lk_match_vec (lk_hit_vec),
    .taken_vec    (taken_vec),
    .target_bus   (target_bus),
    .seq_addr     (seq_addr),
    .hit          (pred_hit),
    .next_addr    (pred_next)
  );

endmodule

// File: rtl/jtp_checker.sv
module jtp_checker #(
  parameter int ADDR_W  = 16,
  parameter int ENTRIES = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              upd_valid,
  input logic [ADDR_W-1:0] upd_addr,
  input logic              upd_taken,
  input logic [ADDR_W-1:0] upd_target,
  input logic              upd_literal,
  input logic              pred_hit,
  input logic [ADDR_W-1:0] pred_next,
  input logic [ENTRIES-1:0] valid_vec,
  input logic [ENTRIES-1:0] lk_hit_vec,
  input logic [ENTRIES-1:0] up_hit_vec
);

  p_empty_in_reset_r1: assert property (@(posedge clk)
    !rst_n |-> (valid_vec == '0));

  p_miss_sequential_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !pred_hit |-> (pred_next == fetch_addr + ADDR_W'(1)));

  p_no_claim_computed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && !upd_literal && (up_hit_vec == '0))
      |=> (valid_vec == $past(valid_vec)));

  p_no_claim_fallthru_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken && (up_hit_vec == '0))
      |=> (valid_vec == $past(valid_vec)));

  p_claim_visible_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && upd_literal)
      |=> (!(fetch_addr == $past(upd_addr)) || (pred_hit && pred_next == $past(upd_target))));

  p_demote_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && !upd_taken)
      |=> ((!(fetch_addr == $past(upd_addr)) || !pred_hit) && (valid_vec == $past(valid_vec))));

  p_refresh_in_place_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_taken && (up_hit_vec != '0)) |=> (valid_vec == $past(valid_vec)));

  p_unique_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_hit_vec) && $onehot0(up_hit_vec));

  p_no_shrink_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 ($countones(valid_vec) >= $countones($past(valid_vec))));

endmodule

bind jump_trace_predictor jtp_checker #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_jtp_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .fetch_addr  (fetch_addr),
  .upd_valid   (upd_valid),
  .upd_addr    (upd_addr),
  .upd_taken   (upd_taken),
  .upd_target  (upd_target),
  .upd_literal (upd_literal),
  .pred_hit    (pred_hit),
  .pred_next   (pred_next),
  .valid_vec   (valid_vec),
  .lk_hit_vec  (lk_hit_vec),
  .up_hit_vec  (up_hit_vec)
);

// File: tb/test_jump_trace_predictor.sv
module test_jump_trace_predictor;

  localparam int AW = 16;
  localparam int NE = 8;
  localparam int SWEEP = 64;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] fetch_addr;
  logic          upd_valid;
  logic [AW-1:0] upd_addr;
  logic          upd_taken;
  logic [AW-1:0] upd_target;
  logic          upd_literal;
  logic          pred_hit;
  logic [AW-1:0] pred_next;

  int checks = 0;
  int errors = 0;

  logic          m_valid [NE];
  logic [AW-1:0] m_tag   [NE];
  logic [AW-1:0] m_tgt   [NE];
  logic          m_bit   [NE];
  int            m_ptr;

  jump_trace_predictor #(.ADDR_W(AW), .ENTRIES(NE)) i_jump_trace_predictor (
    .clk(clk), .rst_n(rst_n), .fetch_addr(fetch_addr),
    .upd_valid(upd_valid), .upd_addr(upd_addr), .upd_taken(upd_taken),
    .upd_target(upd_target), .upd_literal(upd_literal),
    .pred_hit(pred_hit), .pred_next(pred_next)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run hung, actual=expired expected=done");
    summary();
  end

  task automatic model_expect(input logic [AW-1:0] a, output logic eh, output logic [AW-1:0] en);
    eh = 1'b0;
    en = a + 16'd1;
    for (int i = 0; i < NE; i++)
      if (m_valid[i] && m_tag[i] == a && m_bit[i]) begin eh = 1'b1; en = m_tgt[i]; end
  endtask

  task automatic check_at(input logic [AW-1:0] a, input string req);
    logic eh;
    logic [AW-1:0] en;
    fetch_addr = a;
    #1;
    model_expect(a, eh, en);
    checks++;
    if (pred_hit !== eh || pred_next !== en) begin
      errors++;
      $display("FAIL %s addr=%h actual hit=%b next=%h expected hit=%b next=%h",
               req, a, pred_hit, pred_next, eh, en);
    end
  endtask

  task automatic sweep(input string req);
    for (int a = 0; a < SWEEP; a++) check_at(AW'(a), req);
  endtask

  task automatic model_update(input logic [AW-1:0] a, input logic t,
                              input logic [AW-1:0] tg, input logic lit);
    int hit_idx = -1;
    int free_idx = -1;
    for (int i = 0; i < NE; i++) if (m_valid[i] && m_tag[i] == a) hit_idx = i;
    if (hit_idx >= 0) begin
      m_bit[hit_idx] = t;
      if (t) m_tgt[hit_idx] = tg;
    end else if (t && lit) begin
      for (int i = NE - 1; i >= 0; i--) if (!m_valid[i]) free_idx = i;
      if (free_idx < 0) begin
        free_idx = m_ptr;
        m_ptr = (m_ptr + 1) % NE;
      end
      m_valid[free_idx] = 1'b1; m_tag[free_idx] = a;
      m_tgt[free_idx] = tg;     m_bit[free_idx] = 1'b1;
    end
  endtask

  // Drives one update for a cycle; optionally checks the same-cycle lookup (R9).
  task automatic do_update(input logic [AW-1:0] a, input logic t,
                           input logic [AW-1:0] tg, input logic lit, input bit same_cycle);
    @(negedge clk);
    upd_valid = 1'b1; upd_addr = a; upd_taken = t; upd_target = tg; upd_literal = lit;
    if (same_cycle) check_at(a, "R9");
    @(negedge clk);
    upd_valid = 1'b0;
    model_update(a, t, tg, lit);
  endtask

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; fetch_addr = '0; upd_valid = 1'b0; upd_addr = '0;
    upd_taken = 1'b0; upd_target = '0; upd_literal = 1'b0;
    for (int i = 0; i < NE; i++) begin
      m_valid[i] = 1'b0; m_tag[i] = '0; m_tgt[i] = '0; m_bit[i] = 1'b0;
    end
    m_ptr = 0;
    repeat (3) @(negedge clk);
    check_at(16'hffff, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    sweep("R1");

    do_update(16'h0010, 1'b1, 16'h0200, 1'b0, 1'b1);
    check_at(16'h0010, "R3");
    do_update(16'h0011, 1'b0, 16'h0210, 1'b1, 1'b0);
    check_at(16'h0011, "R4");
    do_update(16'h0012, 1'b1, 16'h0300, 1'b1, 1'b1);
    check_at(16'h0012, "R5");
    do_update(16'h0012, 1'b0, 16'h0000, 1'b1, 1'b1);
    check_at(16'h0012, "R6");
    do_update(16'h0012, 1'b1, 16'h0340, 1'b0, 1'b0);
    check_at(16'h0012, "R7");
    sweep("R2");

    for (int k = 0; k < 9; k++) begin
      do_update(AW'(16'h0020 + k), 1'b1, AW'(16'h0400 + 16 * k), 1'b1, 1'b0);
      sweep("R8");
    end
    check_at(16'h0012, "R8");

    lfsr = 16'hace1;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      do_update({10'd0, lfsr[5:0]}, lfsr[7], lfsr ^ 16'h5a5a, lfsr[8] | lfsr[9], 1'b0);
      sweep("R8");
    end
    summary();
  end

endmodule